// File: doc/BRIEF.md
# 8-bit Accumulator Execute Unit

This block is the execute stage of a small accumulator-style 8-bit core whose instructions are 14 bits wide. Each cycle it takes one instruction, reads one byte from its internal data register space and combines it with the working register W or with an 8-bit literal. It then presents the result, where the result goes (W or the data register), a write enable, updated carry / digit-carry / zero flags and a skip request for the sequencer. Program-counter sequencing, the return stack, interrupts, sleep, the watchdog and bank selection belong to other blocks.

Instructions fall into three families, chosen by bits 13:12. Byte operations (`00`) carry a 4-bit operation code in bits 11:8, a destination bit in bit 7 and a 7-bit register address in bits 6:0. Bit operations (`01`) carry a 2-bit code in bits 11:10, a bit index in bits 9:7 and the address. Literal operations (`11`) carry a code in bits 11:8 and the literal in bits 7:0. The family `10` (branches) is handled elsewhere and has no effect here, and neither has any unused code. W, the flags and the register space update on the clock edge where `valid` is high. A second, read-only port lets the surrounding logic look at any register.

Top module: `acc8_exec_unit`

## Requirements
- R1: While `rst_n` is low, W, all three flags and every data register are cleared to 0.
- R2: For a byte operation that writes, bit 7 = 0 sends the result to W (`dest_file`=0) and bit 7 = 1 sends it to the data register addressed by the low ADDR_W bits of bits 6:0 (`dest_file`=1). The write enable is high only when a write happens.
- R3: Code 0111 adds W to the register, code 0010 computes register minus W, literal codes 111x add W to the literal and 110x compute literal minus W. All four update `status[0]`=carry (1 = no borrow for subtraction), `status[1]`=carry out of bit 3 and `status[2]`=zero.
- R4: Byte codes 0001 (clear, result 0), 0011 (decrement), 0100 (OR with W), 0101 (AND with W), 0110 (XOR with W), 1000 (copy), 1001 (invert) and 1010 (increment) update only the zero flag.
- R5: Code 1100 rotates the register right through carry and code 1101 rotates it left through carry. Carry takes the bit shifted out, and zero and digit-carry are kept.
- R6: Code 1110 exchanges the two nibbles of the register, and code 0000 with bit 7 = 1 writes W into the register. Neither changes any flag.
- R7: Bit code 00 clears and bit code 01 sets bit `instr[9:7]` of the addressed register, writing it back. Flags are unchanged.
- R8: Bit code 10 requests a skip when the tested bit is 0, and bit code 11 requests a skip when it is 1. Neither writes anything or changes a flag.
- R9: Byte code 1011 (decrement) and 1111 (increment) write their result per bit 7, request a skip when the 8-bit result is 0 and leave all flags unchanged.
- R10: Literal codes 00xx and 01xx load the literal into W without touching the flags. Codes 1000, 1001 and 1010 OR, AND and XOR the literal into W and update only the zero flag.
- R11: Code 0000 with bit 7 = 0, the whole `10` family and literal code 1011 write nothing, change no flag and request no skip.
- R12: With `valid` low, `wr_en` and `skip` are 0 and W, the flags and the registers hold.
- R13: `peek_data` shows the data register selected by `peek_addr` combinationally, including a write made at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction present, commit at this edge |
| instr | input | 14 | Instruction word |
| peek_addr | input | ADDR_W | Inspection read address |
| result | output | 8 | ALU result of the current instruction |
| dest_file | output | 1 | 1 = result targets the data register, 0 = W |
| wr_en | output | 1 | A write to W or a register happens at this edge |
| skip | output | 1 | Skip the next instruction |
| w_q | output | 8 | Working register |
| status | output | 3 | Flags: bit 0 carry, bit 1 digit carry, bit 2 zero |
| peek_data | output | 8 | Data register at `peek_addr` |

## Verification
The bench builds the unit with ADDR_W = 4, so that all 16 data registers can be preloaded and checked after every instruction. Register addresses with the upper f-field bits set exercise the aliasing of R2. With this small space the bench can sweep every byte code against both destinations and every address, every bit code against every bit index and address, and every literal code against a set of edge values (0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80, 0xFE, 0xFF). Those values are chosen to drive carry, digit carry, zero and the two skip-on-zero cases.

// File: rtl/acc8_exec_pkg.sv
package acc8_exec_pkg;
  localparam int DW = 8;
  localparam int IW = 14;
  localparam int BW = 3;
  localparam int NW = DW / 2;

  typedef enum logic [4:0] {
    OP_NONE, OP_PASS_W, OP_ZERO, OP_SUB_W, OP_ADD_W, OP_DEC, OP_INC,
    OP_IOR, OP_AND, OP_XOR, OP_PASS_A, OP_COM, OP_RRC, OP_RLC,
    OP_SWAP, OP_BCLR, OP_BSET
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_lit;
    logic    wr_w;
    logic    wr_file;
    logic    upd_z;
    logic    upd_dc;
    logic    upd_c;
    logic    skip_on_zero;
    logic    test_bit;
    logic    test_want;
    logic    nop;
  } ctrl_t;

  // returns {carry, digit carry, sum}
  function automatic logic [DW+1:0] add_cdc(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b,
                                            input logic cin);
    logic [NW:0] lo;
    logic [DW:0] full;
    lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + (NW+1)'(cin);
    full = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
    return {full[DW], lo[NW], full[DW-1:0]};
  endfunction

  function automatic logic [DW:0] rot_right(input logic [DW-1:0] a, input logic c);
    return {a[0], c, a[DW-1:1]};
  endfunction

  function automatic logic [DW:0] rot_left(input logic [DW-1:0] a, input logic c);
    return {a[DW-1], a[DW-2:0], c};
  endfunction

  function automatic logic [DW-1:0] swap_nib(input logic [DW-1:0] a);
    return {a[NW-1:0], a[DW-1:NW]};
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_exec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  output ctrl_t         ctrl
);
  logic [1:0] family;
  logic [3:0] code4;
  logic       dbit;

  assign family = instr[13:12];
  assign code4  = instr[11:8];
  assign dbit   = instr[7];

  always_comb begin
    ctrl    = '0;
    ctrl.op = OP_NONE;
    case (family)
      2'b00: begin
        if (code4 == 4'h0) begin
          if (dbit) begin
            ctrl.op      = OP_PASS_W;
            ctrl.wr_file = 1'b1;
          end else begin
            ctrl.nop = 1'b1;
          end
        end else begin
          ctrl.wr_file = dbit;
          ctrl.wr_w    = ~dbit;
          case (code4)
            4'h1: begin ctrl.op = OP_ZERO;   ctrl.upd_z = 1'b1; end
            4'h2: begin ctrl.op = OP_SUB_W;  ctrl.upd_z = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_c = 1'b1; end
            4'h3: begin ctrl.op = OP_DEC;    ctrl.upd_z = 1'b1; end
            4'h4: begin ctrl.op = OP_IOR;    ctrl.upd_z = 1'b1; end
            4'h5: begin ctrl.op = OP_AND;    ctrl.upd_z = 1'b1; end
            4'h6: begin ctrl.op = OP_XOR;    ctrl.upd_z = 1'b1; end
            4'h7: begin ctrl.op = OP_ADD_W;  ctrl.upd_z = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_c = 1'b1; end
            4'h8: begin ctrl.op = OP_PASS_A; ctrl.upd_z = 1'b1; end
            4'h9: begin ctrl.op = OP_COM;    ctrl.upd_z = 1'b1; end
            4'hA: begin ctrl.op = OP_INC;    ctrl.upd_z = 1'b1; end
            4'hB: begin ctrl.op = OP_DEC;    ctrl.skip_on_zero = 1'b1; end
            4'hC: begin ctrl.op = OP_RRC;    ctrl.upd_c = 1'b1; end
            4'hD: begin ctrl.op = OP_RLC;    ctrl.upd_c = 1'b1; end
            4'hE: begin ctrl.op = OP_SWAP; end
            default: begin ctrl.op = OP_INC; ctrl.skip_on_zero = 1'b1; end
          endcase
        end
      end
      2'b01: begin
        case (instr[11:10])
          2'b00:   begin ctrl.op = OP_BCLR; ctrl.wr_file = 1'b1; end
          2'b01:   begin ctrl.op = OP_BSET; ctrl.wr_file = 1'b1; end
          2'b10:   begin ctrl.test_bit = 1'b1; ctrl.test_want = 1'b0; end
          default: begin ctrl.test_bit = 1'b1; ctrl.test_want = 1'b1; end
        endcase
      end
      2'b10: ctrl.nop = 1'b1;
      default: begin
        ctrl.use_lit = 1'b1;
        ctrl.wr_w    = 1'b1;
        casez (code4)
          4'b0???: ctrl.op = OP_PASS_A;
          4'b1000: begin ctrl.op = OP_IOR; ctrl.upd_z = 1'b1; end
          4'b1001: begin ctrl.op = OP_AND; ctrl.upd_z = 1'b1; end
          4'b1010: begin ctrl.op = OP_XOR; ctrl.upd_z = 1'b1; end
          4'b110?: begin ctrl.op = OP_SUB_W; ctrl.upd_z = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_c = 1'b1; end
          4'b111?: begin ctrl.op = OP_ADD_W; ctrl.upd_z = 1'b1; ctrl.upd_dc = 1'b1; ctrl.upd_c = 1'b1; end
          default: begin ctrl.wr_w = 1'b0; ctrl.use_lit = 1'b0; ctrl.nop = 1'b1; end
        endcase
      end
    endcase
  end

  // R2: a result never targets both W and the register space
  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.wr_w, ctrl.wr_file}));

  // R8: bit tests never write or touch flags
  p_test_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (family == 2'b01 && instr[11]) |->
      !ctrl.wr_w && !ctrl.wr_file && !ctrl.upd_z && !ctrl.upd_dc && !ctrl.upd_c);
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_exec_pkg::*;
(
  input  ctrl_t          ctrl,
  input  logic [DW-1:0]  w,
  input  logic [DW-1:0]  fval,
  input  logic [DW-1:0]  lit,
  input  logic [BW-1:0]  bsel,
  input  logic           c_in,
  output logic [DW-1:0]  res,
  output logic           c_out,
  output logic           dc_out,
  output logic           z_out,
  output logic           skip_cond
);
  logic [DW-1:0] opa;
  logic [DW-1:0] bmask;
  logic [DW+1:0] sum_add;
  logic [DW+1:0] sum_sub;
  logic [DW:0]   rr;
  logic [DW:0]   rl;

  assign opa     = ctrl.use_lit ? lit : fval;
  assign bmask   = DW'(1) << bsel;
  assign sum_add = add_cdc(opa, w, 1'b0);
  assign sum_sub = add_cdc(opa, ~w, 1'b1);
  assign rr      = rot_right(fval, c_in);
  assign rl      = rot_left(fval, c_in);

  always_comb begin
    res    = '0;
    c_out  = c_in;
    dc_out = 1'b0;
    case (ctrl.op)
      OP_PASS_W: res = w;
      OP_ZERO:   res = '0;
      OP_SUB_W:  begin res = sum_sub[DW-1:0]; c_out = sum_sub[DW+1]; dc_out = sum_sub[DW]; end
      OP_ADD_W:  begin res = sum_add[DW-1:0]; c_out = sum_add[DW+1]; dc_out = sum_add[DW]; end
      OP_DEC:    res = fval - DW'(1);
      OP_INC:    res = fval + DW'(1);
      OP_IOR:    res = opa | w;
      OP_AND:    res = opa & w;
      OP_XOR:    res = opa ^ w;
      OP_PASS_A: res = opa;
      OP_COM:    res = ~fval;
      OP_RRC:    begin res = rr[DW-1:0]; c_out = rr[DW]; end
      OP_RLC:    begin res = rl[DW-1:0]; c_out = rl[DW]; end
      OP_SWAP:   res = swap_nib(fval);
      OP_BCLR:   res = fval & ~bmask;
      OP_BSET:   res = fval | bmask;
      default:   res = '0;
    endcase
  end

  assign z_out     = (res == '0);
  assign skip_cond = (ctrl.skip_on_zero && z_out) ||
                     (ctrl.test_bit && (fval[bsel] == ctrl.test_want));
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile
  import acc8_exec_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata,
  input  logic [ADDR_W-1:0] paddr,
  output logic [DW-1:0]     pdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign pdata = mem[paddr];

  // R2: a committed register write is stored at its address
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/acc8_exec_unit.sv
module acc8_exec_unit
  import acc8_exec_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [13:0]       instr,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        result,
  output logic              dest_file,
  output logic              wr_en,
  output logic              skip,
  output logic [7:0]        w_q,
  output logic [2:0]        status,
  output logic [7:0]        peek_data
);
  localparam int ST_C  = 0;
  localparam int ST_DC = 1;
  localparam int ST_Z  = 2;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] faddr;
  logic [DW-1:0]     fval;
  logic [DW-1:0]     alu_res;
  logic              alu_c, alu_dc, alu_z, alu_skip;
  logic              rf_we;
  logic              w_we;

  assign faddr = instr[ADDR_W-1:0];

  acc8_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .instr (instr),
    .ctrl  (ctrl)
  );

  acc8_regfile #(.ADDR_W(ADDR_W)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (faddr),
    .wdata (alu_res),
    .raddr (faddr),
    .rdata (fval),
    .paddr (peek_addr),
    .pdata (peek_data)
  );

  acc8_alu u_alu (
    .ctrl      (ctrl),
    .w         (w_q),
    .fval      (fval),
    .lit       (instr[7:0]),
    .bsel      (instr[9:7]),
    .c_in      (status[ST_C]),
    .res       (alu_res),
    .c_out     (alu_c),
    .dc_out    (alu_dc),
    .z_out     (alu_z),
    .skip_cond (alu_skip)
  );

  assign rf_we     = valid & ctrl.wr_file;
  assign w_we      = valid & ctrl.wr_w;
  assign wr_en     = rf_we | w_we;
  assign dest_file = ctrl.wr_file;
  assign result    = alu_res;
  assign skip      = valid & alu_skip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q    <= '0;
      status <= '0;
    end else if (valid) begin
      if (ctrl.wr_w)   w_q          <= alu_res;
      if (ctrl.upd_c)  status[ST_C]  <= alu_c;
      if (ctrl.upd_dc) status[ST_DC] <= alu_dc;
      if (ctrl.upd_z)  status[ST_Z]  <= alu_z;
    end
  end

  // R12: idle cycles hold all architectural state
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(w_q) && $stable(status));

  // R11: unused codes produce no write and no skip
  p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.nop) |-> !wr_en && !skip);

  // R11: unused codes leave W and flags alone
  p_nop_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.nop) |=> $stable(w_q) && $stable(status));

  // R4: zero flag reflects the committed result
  p_z_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.upd_z) |=> status[ST_Z] == ($past(result) == 8'h00));

  // R5: right rotate moves bit 0 into carry
  p_rot_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.op == OP_RRC) |=> status[ST_C] == $past(fval[0]));
endmodule

// File: tb/acc8_exec_unit_bench.sv
module acc8_exec_unit_bench;
  localparam int AW   = 4;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [13:0]   instr = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [7:0]    result, w_q, peek_data;
  logic          dest_file, wr_en, skip;
  logic [2:0]    status;

  always #5 clk = ~clk;

  acc8_exec_unit #(.ADDR_W(AW)) u_acc8_exec_unit (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr),
    .peek_addr(peek_addr), .result(result), .dest_file(dest_file),
    .wr_en(wr_en), .skip(skip), .w_q(w_q), .status(status),
    .peek_data(peek_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  int m_w;
  int m_st;
  int m_mem [NREG];

  int    e_res, e_st, e_fi;
  bit    e_wrw, e_wrf, e_skip;
  string e_tag;

  int spec [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF};
  int wl   [6] = '{8'h00, 8'h01, 8'h0F, 8'hFF, 8'h80, 8'h7F};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // sum with carry and nibble carry, then sets all three flags
  task automatic arith(input int x, input int y, input int ci);
    int s;
    s     = x + y + ci;
    e_res = s % 256;
    e_st  = ((e_res == 0) ? 4 : 0) + ((((x % 16) + (y % 16) + ci) > 15) ? 2 : 0) + ((s > 255) ? 1 : 0);
  endtask

  function automatic int with_z(input int st, input int r);
    return (st % 4) + ((r == 0) ? 4 : 0);
  endfunction

  task automatic predict(input logic [13:0] i);
    int fv, wv, k, o4, b, cin;
    bit d;
    e_fi  = int'(i[6:0]) % NREG;
    fv    = m_mem[e_fi];
    wv    = m_w;
    k     = int'(i[7:0]);
    o4    = int'(i[11:8]);
    d     = i[7];
    b     = int'(i[9:7]);
    cin   = m_st % 2;
    e_res = 0; e_wrw = 0; e_wrf = 0; e_skip = 0; e_st = m_st; e_tag = "R11";
    case (i[13:12])
      2'b00: begin
        if (o4 == 0) begin
          if (d) begin e_res = wv; e_wrf = 1; e_tag = "R6"; end
        end else begin
          e_wrf = d; e_wrw = !d; e_tag = "R4";
          case (o4)
            1:  e_res = 0;
            2:  begin arith(fv, 255 - wv, 1); e_tag = "R3"; end
            3:  e_res = (fv + 255) % 256;
            4:  e_res = fv | wv;
            5:  e_res = fv & wv;
            6:  e_res = fv ^ wv;
            7:  begin arith(fv, wv, 0); e_tag = "R3"; end
            8:  e_res = fv;
            9:  e_res = 255 - fv;
            10: e_res = (fv + 1) % 256;
            11: begin e_res = (fv + 255) % 256; e_skip = (e_res == 0); e_tag = "R9"; end
            12: begin e_res = fv / 2 + cin * 128; e_st = (m_st / 2) * 2 + fv % 2; e_tag = "R5"; end
            13: begin e_res = (fv * 2) % 256 + cin; e_st = (m_st / 2) * 2 + fv / 128; e_tag = "R5"; end
            14: begin e_res = (fv % 16) * 16 + fv / 16; e_tag = "R6"; end
            default: begin e_res = (fv + 1) % 256; e_skip = (e_res == 0); e_tag = "R9"; end
          endcase
          if (o4 == 1 || o4 == 3 || (o4 >= 4 && o4 <= 6) || (o4 >= 8 && o4 <= 10))
            e_st = with_z(m_st, e_res);
        end
      end
      2'b01: begin
        case (i[11:10])
          2'b00: begin e_res = fv & (255 - (1 << b)); e_wrf = 1; e_tag = "R7"; end
          2'b01: begin e_res = fv | (1 << b); e_wrf = 1; e_tag = "R7"; end
          2'b10: begin e_skip = ((fv >> b) % 2) == 0; e_tag = "R8"; end
          default: begin e_skip = ((fv >> b) % 2) == 1; e_tag = "R8"; end
        endcase
      end
      2'b10: e_tag = "R11";
      default: begin
        e_tag = "R10";
        if (o4 < 8) begin e_res = k; e_wrw = 1; end
        else if (o4 == 8)  begin e_res = k | wv; e_wrw = 1; e_st = with_z(m_st, e_res); end
        else if (o4 == 9)  begin e_res = k & wv; e_wrw = 1; e_st = with_z(m_st, e_res); end
        else if (o4 == 10) begin e_res = k ^ wv; e_wrw = 1; e_st = with_z(m_st, e_res); end
        else if (o4 == 11) e_tag = "R11";
        else if (o4 <= 13) begin arith(k, 255 - wv, 1); e_wrw = 1; e_tag = "R3"; end
        else begin arith(k, wv, 0); e_wrw = 1; e_tag = "R3"; end
      end
    endcase
  endtask

  task automatic run(input logic [13:0] i);
    @(negedge clk);
    instr = i; valid = 1'b1;
    predict(i);
    peek_addr = AW'(e_fi);
    #1;
    chk(e_tag, "wr_en", int'(wr_en), int'(e_wrw | e_wrf));
    chk(e_tag, "skip", int'(skip), int'(e_skip));
    if (e_wrw | e_wrf) begin
      chk(e_tag, "result", int'(result), e_res);
      chk("R2", "dest_file", int'(dest_file), int'(e_wrf));
    end
    if (e_wrw) m_w = e_res;
    if (e_wrf) m_mem[e_fi] = e_res;
    m_st = e_st;
    @(posedge clk); #1;
    chk(e_tag, "w_q", int'(w_q), m_w);
    chk(e_tag, "status", int'(status), m_st);
    chk("R13", "peek_data", int'(peek_data), m_mem[e_fi]);
  endtask

  task automatic idle(input logic [13:0] i);
    int fi;
    fi = int'(i[6:0]) % NREG;
    @(negedge clk);
    instr = i; valid = 1'b0; peek_addr = AW'(fi);
    #1;
    chk("R12", "idle wr_en", int'(wr_en), 0);
    chk("R12", "idle skip", int'(skip), 0);
    @(posedge clk); #1;
    chk("R12", "idle w_q", int'(w_q), m_w);
    chk("R12", "idle status", int'(status), m_st);
    chk("R12", "idle register", int'(peek_data), m_mem[fi]);
  endtask

  task automatic preload(input int p);
    for (int a = 0; a < NREG; a++) begin
      run(14'h3000 | 14'(spec[(a + p) % 8]));
      run(14'h0080 | 14'(a));
    end
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_w = 0; m_st = 0;
    for (int a = 0; a < NREG; a++) m_mem[a] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "reset w_q", int'(w_q), 0);
    chk("R1", "reset status", int'(status), 0);
    for (int a = 0; a < NREG; a++) begin
      peek_addr = AW'(a); #1;
      chk("R1", "reset register", int'(peek_data), 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // byte operations: every code, both destinations, every register, aliased addresses
    for (int p = 0; p < 6; p++) begin
      preload(p);
      for (int o = 0; o < 16; o++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < NREG; a++) begin
            run(14'h3000 | 14'(wl[(a + o + p) % 6]));
            run({2'b00, 4'(o), 1'(d), 7'(a + NREG * ((o + p) % 8))});
          end
    end

    // bit operations R7 / R8
    for (int p = 0; p < 2; p++) begin
      preload(p + 3);
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 8; b++)
          for (int a = 0; a < NREG; a++)
            run({2'b01, 2'(c), 3'(b), 7'(a + 32 * p)});
    end

    // literal operations R10 / R3
    for (int o = 0; o < 16; o++)
      for (int ki = 0; ki < 8; ki++)
        for (int wi = 0; wi < 6; wi++) begin
          run(14'h3000 | 14'(wl[wi]));
          run({2'b11, 4'(o), 8'(spec[ki])});
        end

    // unused codes R11
    preload(1);
    for (int f = 0; f < 128; f++) run({7'b0000000, 7'(f)});
    for (int j = 0; j < 64; j++) run(14'h2000 | 14'((j * 197) % 4096));
    for (int k = 0; k < 8; k++) run({6'b111011, 8'(spec[k])});

    // valid low R12
    idle(14'h3055);
    idle(14'h0183);
    idle(14'h1785);
    idle(14'h0A82);
    run(14'h0A82);

    @(negedge clk); valid = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule